// File: doc/BRIEF.md
# Machine-Cycle Bus Sequencer for an 8-bit Processor Core

This block sits between an 8-bit processor core and its external memory and I/O bus. The core hands it one machine-cycle request at a time. Each request carries a cycle kind, a 16-bit address and, for writes, a data byte. The block then plays out that cycle on the bus, one T-state per clock. It drives the address, the active-low strobes and a separate output data bus. It samples a separate input data bus and returns the byte read, together with a one-clock completion pulse.

Each cycle kind has its own T-state pattern. An opcode fetch spends its first T-state on the fetch strobes and its remaining three on a refresh phase, during which a 7-bit refresh counter is driven on the address bus. Ordinary memory reads and writes take three T-states. I/O cycles take four, because an automatic wait T-state is added. An external wait input stretches the last strobe T-state of any cycle. All timing is counted in clocks, so the same design works whether the clock runs at the nominal 3.5 MHz or at a multiple of it.

Top module: `bus_cycle_seq`

## Requirements
- R1: Opcode fetch (kind code 0) lasts 4 T-states. In T1, m1_n, mreq_n and rd_n are low. In T2 to T4, m1_n and rd_n are high while mreq_n and rfsh_n are low and bus_addr carries the refresh address. In T1, bus_addr is the request address. The byte on bus_din is captured at the clock edge that ends T1.
- R2: The refresh address is zero in bits 15 to 7. Its low 7 bits are a counter that starts at 0 after reset, increments by one at the end of every opcode fetch, and wraps from 127 to 0.
- R3: Memory read (kind code 1) lasts 3 T-states. mreq_n and rd_n are low in T1 and T2, and every strobe is high in T3. bus_din is captured at the edge that ends T2.
- R4: Memory write (kind code 2) lasts 3 T-states, with mreq_n and wr_n low in T1 and T2. bus_dout shows the write byte from T1 onward. bus_dout keeps that byte after the cycle, through later non-write cycles, until the next write is accepted.
- R5: I/O read (kind code 3) and I/O write (kind code 4) last 4 T-states. T1 carries the address only. iorq_n is low together with rd_n (read) or wr_n (write) in T2 and T3, where T3 is the automatic wait. Every strobe is high in T4. An I/O read captures bus_din at the edge that ends T3.
- R6: wait_n is sampled at the edge that ends the last strobe T-state of a cycle. Each low sample adds one more T-state with the strobes and address held. Read data is captured at the edge that ends the final stretched T-state.
- R7: rsp_done is high for exactly the one clock that follows the final T-state, and rsp_rdata then holds the captured byte. All strobes are high in that clock and in idle clocks. A request is accepted only in the clock after rsp_done, never during it.
- R8: While a cycle is in progress, req_valid is ignored. A request whose kind code is 5, 6 or 7 is also ignored: no strobe falls and rsp_done stays low.
- R9: After reset, all strobes are high, rsp_done is low, and bus_addr, bus_dout and rsp_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, taken only when idle |
| req_kind | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| req_addr | input | 16 | Address of the requested cycle |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-clock pulse after a cycle ends |
| rsp_rdata | output | 8 | Byte captured by the last read-type cycle |
| bus_addr | output | 16 | Address bus, refresh address during the fetch refresh phase |
| bus_dout | output | 8 | Output data bus, holds the last written byte |
| bus_din | input | 8 | Input data bus |
| wait_n | input | 1 | Active-low wait request from the bus |
| mreq_n | output | 1 | Memory request strobe |
| iorq_n | output | 1 | I/O request strobe |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| m1_n | output | 1 | Opcode fetch marker |
| rfsh_n | output | 1 | Refresh strobe |

## Verification
The bench builds the block with its default parameters: 16 address bits, 8 data bits, a 7-bit refresh counter and one automatic I/O wait T-state. The 7-bit counter lets a run of 130 fetches cross the 127-to-0 wrap, and confirms that bit 7 and above stay zero throughout. The single automatic wait gives the four-T-state I/O pattern. Stretching the cycles by one to three wait_n samples shows that data is captured at the end of the stretched T-state and not before.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } kind_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_STRB,
      PH_POST,
      PH_DONE
   } phase_t;

   typedef struct packed {
      logic m1;
      logic mreq;
      logic iorq;
      logic rd;
      logic wr;
      logic rfsh;
   } strobe_t;

   function automatic logic is_io(kind_t k);
      return (k == K_IORD) || (k == K_IOWR);
   endfunction

   function automatic logic is_read(kind_t k);
      return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
   endfunction

   function automatic logic is_write(kind_t k);
      return (k == K_MWR) || (k == K_IOWR);
   endfunction

   // T-states spent in one phase of a machine cycle
   function automatic int unsigned phase_len(kind_t k, phase_t p, int unsigned io_waits);
      case (p)
         PH_PRE:  return is_io(k) ? 1 : 0;
         PH_STRB: return (k == K_FETCH) ? 1 : (is_io(k) ? 1 + io_waits : 2);
         PH_POST: return (k == K_FETCH) ? 3 : 1;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/bseq_timer.sv
module bseq_timer
   import busseq_pkg::*;
#(
   parameter int IO_WAITS = 1,
   parameter int CNT_W    = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_kind,
   input  logic       wait_n,
   output phase_t     phase,
   output kind_t      kind,
   output logic       accept,
   output logic       cap_en,
   output logic       fetch_end
);

   phase_t             ph_q;
   kind_t              k_q;
   logic [CNT_W-1:0]   cnt_q;
   int unsigned        cur_len;
   logic               at_last;
   kind_t              req_k;

   assign req_k = kind_t'(req_kind);

   always_comb begin
      cur_len = phase_len(k_q, ph_q, IO_WAITS);
      at_last = (cnt_q == CNT_W'(cur_len - 1));
   end

   assign accept = (ph_q == PH_IDLE) && req_valid && (req_kind <= 3'd4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         k_q   <= K_FETCH;
         cnt_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: if (accept) begin
               k_q   <= req_k;
               cnt_q <= '0;
               ph_q  <= (phase_len(req_k, PH_PRE, IO_WAITS) != 0) ? PH_PRE : PH_STRB;
            end
            PH_PRE: if (at_last) begin
               ph_q  <= PH_STRB;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_STRB: if (at_last) begin
               if (wait_n) begin
                  ph_q  <= PH_POST;
                  cnt_q <= '0;
               end
            end else cnt_q <= cnt_q + 1'b1;
            PH_POST: if (at_last) begin
               ph_q  <= PH_DONE;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign phase     = ph_q;
   assign kind      = k_q;
   assign cap_en    = (ph_q == PH_STRB) && at_last && wait_n && is_read(k_q);
   assign fetch_end = (ph_q == PH_POST) && at_last && (k_q == K_FETCH);

   // R6: a low wait sample keeps the strobe phase exactly where it is
   p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_STRB && at_last && !wait_n) |=> (ph_q == PH_STRB && $stable(cnt_q)));

   // R7: the completion clock is a single clock
   p_done_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DONE) |=> (ph_q == PH_IDLE));

   // R8: the cycle kind cannot change once a cycle has started
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE) |=> $stable(k_q));

endmodule

// File: rtl/bseq_strobe_dec.sv
module bseq_strobe_dec
   import busseq_pkg::*;
(
   input  phase_t  phase,
   input  kind_t   kind,
   output strobe_t strb
);

   always_comb begin
      strb = '0;
      if (phase == PH_STRB) begin
         case (kind)
            K_FETCH: begin strb.m1 = 1'b1; strb.mreq = 1'b1; strb.rd = 1'b1; end
            K_MRD:   begin strb.mreq = 1'b1; strb.rd = 1'b1; end
            K_MWR:   begin strb.mreq = 1'b1; strb.wr = 1'b1; end
            K_IORD:  begin strb.iorq = 1'b1; strb.rd = 1'b1; end
            K_IOWR:  begin strb.iorq = 1'b1; strb.wr = 1'b1; end
            default: strb = '0;
         endcase
      end else if (phase == PH_POST && kind == K_FETCH) begin
         strb.mreq = 1'b1;
         strb.rfsh = 1'b1;
      end
   end

endmodule

// File: rtl/bseq_rfsh_ctr.sv
module bseq_rfsh_ctr #(
   parameter int RFSH_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   output logic [RFSH_W-1:0] cnt
);

   logic [RFSH_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt = cnt_q;

   // R2: one step per finished fetch, wrapping at the counter width
   p_rfsh_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      inc |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_rfsh_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import busseq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int RFSH_W   = 7,
   parameter int IO_WAITS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              wait_n,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              m1_n,
   output logic              rfsh_n
);

   localparam int CNT_W = $clog2(IO_WAITS + 4);

   if (RFSH_W < 1 || RFSH_W > ADDR_W) begin : g_bad_rfsh
      $error("bus_cycle_seq: RFSH_W must lie in 1..ADDR_W");
   end
   if (IO_WAITS < 0 || IO_WAITS > 15) begin : g_bad_waits
      $error("bus_cycle_seq: IO_WAITS must lie in 0..15");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("bus_cycle_seq: bus widths must be positive");
   end

   phase_t            ph;
   kind_t             kd;
   logic              accept;
   logic              cap_en;
   logic              fetch_end;
   strobe_t           strb;
   logic [RFSH_W-1:0] rf_cnt;
   logic [ADDR_W-1:0] rfsh_addr;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] dout_q;
   logic [DATA_W-1:0] rdata_q;

   bseq_timer #(.IO_WAITS(IO_WAITS), .CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .wait_n    (wait_n),
      .phase     (ph),
      .kind      (kd),
      .accept    (accept),
      .cap_en    (cap_en),
      .fetch_end (fetch_end)
   );

   bseq_strobe_dec u_dec (
      .phase (ph),
      .kind  (kd),
      .strb  (strb)
   );

   bseq_rfsh_ctr #(.RFSH_W(RFSH_W)) u_rfsh (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fetch_end),
      .cnt   (rf_cnt)
   );

   if (ADDR_W > RFSH_W) begin : g_rfsh_pad
      assign rfsh_addr = {{(ADDR_W-RFSH_W){1'b0}}, rf_cnt};
   end else begin : g_rfsh_full
      assign rfsh_addr = rf_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr <= '0;
         dout_q   <= '0;
         rdata_q  <= '0;
      end else begin
         if (accept) lat_addr <= req_addr;
         if (accept && is_write(kind_t'(req_kind))) dout_q <= req_wdata;
         if (cap_en) rdata_q <= bus_din;
      end
   end

   assign bus_addr  = (ph == PH_POST && kd == K_FETCH) ? rfsh_addr : lat_addr;
   assign bus_dout  = dout_q;
   assign rsp_rdata = rdata_q;
   assign rsp_done  = (ph == PH_DONE);

   assign mreq_n = ~strb.mreq;
   assign iorq_n = ~strb.iorq;
   assign rd_n   = ~strb.rd;
   assign wr_n   = ~strb.wr;
   assign m1_n   = ~strb.m1;
   assign rfsh_n = ~strb.rfsh;

   // R1: fetch marker and refresh strobe never overlap
   p_m1_rfsh_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(!m1_n && !rfsh_n));

   // R2: refresh runs with a memory request and no data strobe
   p_rfsh_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (!mreq_n && rd_n && wr_n && m1_n));

   // R5: an I/O request carries exactly one direction strobe and no memory request
   p_io_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !iorq_n |-> (mreq_n && (rd_n != wr_n)));

   // R4: output data moves only when a write is accepted
   p_dout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && is_write(kind_t'(req_kind))) |=> $stable(bus_dout));

   // R7: the bus is quiet around the completion pulse and when idle
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE || ph == PH_DONE) |-> (mreq_n && iorq_n && rd_n && wr_n && m1_n && rfsh_n));

   // R7: returned data changes only at a capture edge
   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(rsp_rdata));

endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic [15:0] bus_addr;
   logic [7:0]  bus_dout;
   logic [7:0]  bus_din = 8'h0;
   logic        wait_n = 1'b1;
   logic        mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;

   int checks = 0;
   int errors = 0;
   int rf = 0;

   always #10 clk = ~clk;

   bus_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .bus_din(bus_din), .wait_n(wait_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
      .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n)
   );

   // active-high view, bits {m1, mreq, iorq, rd, wr, rfsh}
   function automatic logic [5:0] act();
      return {~m1_n, ~mreq_n, ~iorq_n, ~rd_n, ~wr_n, ~rfsh_n};
   endfunction

   // ph: 0 address-only, 1 strobe, 2 after strobe
   function automatic logic [5:0] exp_strb(int kind, int ph);
      if (ph == 1) begin
         case (kind)
            0: return 6'b110100;
            1: return 6'b010100;
            2: return 6'b010010;
            3: return 6'b001100;
            default: return 6'b001010;
         endcase
      end
      if (ph == 2 && kind == 0) return 6'b010001;
      return 6'b000000;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int a, input int e);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
      end
   endtask

   // Runs one machine cycle and checks every T-state of it
   task automatic do_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rdv, input int waits, input string tag);
      int pre, s0, post, n, ph;
      logic [15:0] ea;
      pre  = (kind >= 3) ? 1 : 0;
      s0   = (kind == 0) ? 1 : 2;
      post = (kind == 0) ? 3 : 1;
      n    = pre + s0 + waits + post;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(kind); req_addr = a; req_wdata = wd;
      bus_din = rdv; wait_n = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < n; t++) begin
         wait_n = !(t >= pre + s0 - 1 && t < pre + s0 - 1 + waits);
         if (t == pre + s0 + waits) bus_din = ~rdv;
         ph = (t < pre) ? 0 : (t < pre + s0 + waits) ? 1 : 2;
         chk(act() == exp_strb(kind, ph), tag, $sformatf("strobes T%0d", t + 1),
             int'(act()), int'(exp_strb(kind, ph)));
         ea = (kind == 0 && ph == 2) ? 16'(rf & 127) : a;
         chk(bus_addr == ea, tag, $sformatf("address T%0d", t + 1), int'(bus_addr), int'(ea));
         chk(rsp_done == 1'b0, "R7", "done during cycle", int'(rsp_done), 0);
         if (kind == 2 || kind == 4)
            chk(bus_dout == wd, tag, "write data on bus", int'(bus_dout), int'(wd));
         @(negedge clk);
      end
      wait_n = 1'b1;
      chk(rsp_done == 1'b1, "R7", "done after last T-state", int'(rsp_done), 1);
      chk(act() == 6'b0, "R7", "strobes in done clock", int'(act()), 0);
      if (kind == 0 || kind == 1 || kind == 3)
         chk(rsp_rdata == rdv, tag, "captured read byte", int'(rsp_rdata), int'(rdv));
      if (kind == 0) rf = (rf + 1) % 128;
      @(negedge clk);
      chk(rsp_done == 1'b0, "R7", "done single clock", int'(rsp_done), 0);
   endtask

   task automatic t_reset();
      chk(act() == 6'b0, "R9", "strobes after reset", int'(act()), 0);
      chk(rsp_done == 1'b0, "R9", "done after reset", int'(rsp_done), 0);
      chk(bus_addr == 16'h0, "R9", "address after reset", int'(bus_addr), 0);
      chk(bus_dout == 8'h0, "R9", "dout after reset", int'(bus_dout), 0);
      chk(rsp_rdata == 8'h0, "R9", "rdata after reset", int'(rsp_rdata), 0);
   endtask

   task automatic t_plain_cycles();
      do_cycle(0, 16'h1234, 8'h00, 8'hA5, 0, "R1");
      do_cycle(1, 16'h8001, 8'h00, 8'h3C, 0, "R3");
      do_cycle(2, 16'h4002, 8'h96, 8'h00, 0, "R4");
      do_cycle(3, 16'h00FE, 8'h00, 8'h5A, 0, "R5");
      do_cycle(4, 16'h01FE, 8'h07, 8'h00, 0, "R5");
   endtask

   task automatic t_write_hold();
      do_cycle(2, 16'h2222, 8'hC3, 8'h00, 0, "R4");
      do_cycle(0, 16'h2223, 8'h00, 8'h11, 0, "R1");
      do_cycle(1, 16'h2224, 8'h00, 8'h22, 0, "R3");
      chk(bus_dout == 8'hC3, "R4", "dout held after later reads", int'(bus_dout), 8'hC3);
   endtask

   task automatic t_waits();
      do_cycle(1, 16'h3000, 8'h00, 8'h77, 2, "R6");
      do_cycle(0, 16'h3001, 8'h00, 8'h88, 1, "R6");
      do_cycle(3, 16'h3002, 8'h00, 8'h99, 3, "R6");
      do_cycle(4, 16'h3003, 8'h4E, 8'h00, 1, "R6");
   endtask

   task automatic t_busy_ignore();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h5555; bus_din = 8'h6D;
      @(negedge clk);
      req_kind = 3'd2; req_addr = 16'hBEEF; req_wdata = 8'hEE;
      for (int t = 0; t < 3; t++) begin
         chk(wr_n == 1'b1, "R8", "no write strobe while busy", int'(wr_n), 1);
         chk(bus_addr == 16'h5555, "R8", "address kept while busy", int'(bus_addr), 16'h5555);
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(rsp_done == 1'b1, "R8", "read completes normally", int'(rsp_done), 1);
      chk(rsp_rdata == 8'h6D, "R8", "read byte unaffected", int'(rsp_rdata), 8'h6D);
      @(negedge clk);
      @(negedge clk);
      chk(act() == 6'b0, "R8", "ignored request never runs", int'(act()), 0);
      chk(bus_dout != 8'hEE, "R8", "ignored write left dout", int'(bus_dout), 8'hEE);
   endtask

   task automatic t_bad_kind();
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h7777;
         @(negedge clk);
         req_valid = 1'b0;
         for (int t = 0; t < 3; t++) begin
            chk(act() == 6'b0 && rsp_done == 1'b0, "R8",
                $sformatf("kind %0d ignored", k), int'({rsp_done, act()}), 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h6000; bus_din = 8'h42;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(rsp_done == 1'b1, "R7", "done clock reached", int'(rsp_done), 1);
      req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h6001; req_wdata = 8'h24;
      @(negedge clk);
      chk(act() == 6'b0, "R7", "no accept during done", int'(act()), 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(act() == 6'b010010, "R7", "accepted in clock after done", int'(act()), 6'b010010);
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(rsp_done == 1'b1, "R7", "second cycle done", int'(rsp_done), 1);
      @(negedge clk);
   endtask

   task automatic t_rfsh_wrap();
      for (int i = 0; i < 130; i++)
         do_cycle(0, 16'(16'h9000 + i), 8'h00, 8'(i), 0, "R2");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_plain_cycles();
      t_write_hold();
      t_waits();
      t_busy_ignore();
      t_bad_kind();
      t_back_to_back();
      t_rfsh_wrap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule